// File: doc/BRIEF.md
# Cache Tag Array with Lookup

This block keeps the tag side of a four-way set-associative cache with 16-byte lines. For every set and way it holds a valid flag, a dirty flag and the tag taken from the upper address bits. A 32-bit lookup address is split into byte offset, set index and tag. The stored tags of the indexed set are compared against the lookup tag, and one cycle later the block reports a hit bit per way, a combined hit, the number of the hitting way and that way's dirty flag.

Around the lookup path the block takes three update commands: a line fill into a chosen way, a dirty mark when a write hits, and an invalidate. It also has a victim report port. The replacement policy picks a way outside the block. The port then returns that way's state and tag before a fill overwrites it, so that a write-back can be scheduled.

The three most significant address bits act as shadow bits. They are cleared in every tag, both when the tag is stored and when it is compared. Reset clears only the flags. Stored tags keep their values.

Top module: `ctag_lookup`

## Requirements
- R1: Bits 3..0 of any address are the byte offset and have no effect on the tag array. Bits 9..4 are the set index, giving 64 sets. Bits 31..10 form the 22-bit tag. A lookup whose address differs from a filled one only in the offset hits. A lookup that differs in a set bit or a tag bit misses.
- R2: In the cycle after `lkp_req` is sampled high, `res_vld` is 1. Bit w of `hit_vec` is 1 exactly when way w of the indexed set is valid and its stored tag equals the masked lookup tag. In any cycle after `lkp_req` was low, `res_vld`, `hit_vec`, `hit_any`, `hit_way` and `hit_dirty` are all 0.
- R3: `hit_any` is 1 when any way hits. `hit_way` is the lowest-numbered hitting way, or 0 when no way hits. `hit_dirty` is the dirty flag of that lowest hitting way, or 0 when no way hits.
- R4: Tag bits 21..19 (address bits 31..29) are forced to 0 on store and on compare. Addresses that differ only in bits 31..29 therefore match the same entry, and a reported victim tag always has those three bits at 0.
- R5: A fill stores the masked tag of `fill_addr` into way `fill_way` of its set. It sets valid to 1 and dirty to 0.
- R6: A mark selects an entry by the set bits of `mark_addr` and by `mark_way`; its tag bits are not used. The mark sets that entry's dirty flag only if the entry is valid. A mark on an invalid entry changes nothing.
- R7: An invalidate clears both the valid flag and the dirty flag of the entry selected by `drop_addr` and `drop_way`.
- R8: When several commands name the same entry in one cycle, fill wins over invalidate, and invalidate wins over mark. Commands aimed at different entries in the same cycle all take effect.
- R9: A lookup or victim request in the same cycle as an update reports the entry state from before that update.
- R10: In the cycle after `vict_req` is sampled high, `vict_vld` is 1 and `vict_live`, `vict_dirty` and `vict_tag` report the valid flag, dirty flag and stored 22-bit tag of way `vict_way` in the set of `vict_addr`. In any cycle after `vict_req` was low, all four victim outputs are 0.
- R11: An asynchronous active-low reset clears every valid flag, every dirty flag and all outputs. Stored tags survive reset. A victim report after reset returns an earlier filled tag with `vict_live` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lkp_req | input | 1 | Lookup request |
| lkp_addr | input | 32 | Lookup address |
| fill_en | input | 1 | Line fill command |
| fill_addr | input | 32 | Address of the line being filled |
| fill_way | input | 2 | Way that receives the fill |
| mark_en | input | 1 | Write-hit dirty mark command |
| mark_addr | input | 32 | Address selecting the set to mark |
| mark_way | input | 2 | Way to mark |
| drop_en | input | 1 | Invalidate command |
| drop_addr | input | 32 | Address selecting the set to invalidate |
| drop_way | input | 2 | Way to invalidate |
| vict_req | input | 1 | Victim report request |
| vict_addr | input | 32 | Address selecting the victim set |
| vict_way | input | 2 | Way chosen for replacement |
| res_vld | output | 1 | Lookup result valid |
| hit_vec | output | 4 | Per-way hit |
| hit_any | output | 1 | Any way hit |
| hit_way | output | 2 | Lowest hitting way |
| hit_dirty | output | 1 | Dirty flag of the hitting way |
| vict_vld | output | 1 | Victim report valid |
| vict_live | output | 1 | Victim entry valid flag |
| vict_dirty | output | 1 | Victim entry dirty flag |
| vict_tag | output | 22 | Victim entry stored tag |

## Verification
The bench builds the block with its default parameters: 32 address bits, four ways, 64 sets and 16-byte lines. The tag is therefore the full 22-bit field with three shadow bits. This lets directed stimulus aim at set 0, set 1 and set 63 with tags chosen bit by bit, so the offset, index and shadow boundaries can be hit exactly. The randomized phase draws addresses from a small pool of tags and sets with random shadow and offset bits. Every combination of two or three commands on the same entry or on different entries then occurs many times, including repeated fills of one tag into several ways of a set.

// File: rtl/ctag_pkg.sv
package ctag_pkg;

  // Next-state action for one stored entry in a cycle.
  typedef enum logic [1:0] {
    UPD_KEEP = 2'd0,
    UPD_MARK = 2'd1,
    UPD_DROP = 2'd2,
    UPD_FILL = 2'd3
  } upd_e;

  // Resolve the commands aimed at one entry: fill > invalidate > mark.
  // A mark only acts on a live entry.
  function automatic upd_e pick_update(input logic fill_hit, input logic drop_hit,
                                       input logic mark_hit, input logic live);
    if (fill_hit) return UPD_FILL;
    if (drop_hit) return UPD_DROP;
    if (mark_hit && live) return UPD_MARK;
    return UPD_KEEP;
  endfunction

endpackage

// File: rtl/ctag_addr_split.sv
module ctag_addr_split #(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 4,
  parameter int IDX_W    = 6,
  parameter int TAG_W    = 22,
  parameter int SHADOW_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);

  // Clear the shadow bits at the top of a raw tag.
  function automatic logic [TAG_W-1:0] shadow_clear(input logic [TAG_W-1:0] raw);
    logic [TAG_W-1:0] keep;
    keep = '1;
    keep = keep >> SHADOW_W;
    return raw & keep;
  endfunction

  assign idx = addr[OFF_W +: IDX_W];
  assign tag = shadow_clear(addr[ADDR_W-1 -: TAG_W]);

  logic unused_offset;
  assign unused_offset = ^addr[OFF_W-1:0];

endmodule

// File: rtl/ctag_way_store.sv
module ctag_way_store
  import ctag_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int IDX_W = 6,
  parameter int TAG_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             drop_we,
  input  logic [IDX_W-1:0] drop_idx,
  input  logic             mark_we,
  input  logic [IDX_W-1:0] mark_idx,
  input  logic [IDX_W-1:0] look_idx,
  output logic             look_valid,
  output logic             look_dirty,
  output logic [TAG_W-1:0] look_tag,
  input  logic [IDX_W-1:0] vict_idx,
  output logic             vict_valid,
  output logic             vict_dirty,
  output logic [TAG_W-1:0] vict_tag
);

  logic [SETS-1:0]  valid_q;
  logic [SETS-1:0]  dirty_q;
  logic [TAG_W-1:0] tag_q [SETS];
  upd_e             set_op [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    assign set_op[s] = pick_update(fill_we && (fill_idx == IDX_W'(s)),
                                   drop_we && (drop_idx == IDX_W'(s)),
                                   mark_we && (mark_idx == IDX_W'(s)),
                                   valid_q[s]);
  end

  // Flags: reset to zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        case (set_op[s])
          UPD_FILL: begin valid_q[s] <= 1'b1; dirty_q[s] <= 1'b0; end
          UPD_DROP: begin valid_q[s] <= 1'b0; dirty_q[s] <= 1'b0; end
          UPD_MARK: dirty_q[s] <= 1'b1;
          default:  ;
        endcase
      end
    end
  end

  // Tags: no reset.
  always_ff @(posedge clk) begin
    if (fill_we) tag_q[fill_idx] <= fill_tag;
  end

  assign look_valid = valid_q[look_idx];
  assign look_dirty = dirty_q[look_idx];
  assign look_tag   = tag_q[look_idx];
  assign vict_valid = valid_q[vict_idx];
  assign vict_dirty = dirty_q[vict_idx];
  assign vict_tag   = tag_q[vict_idx];

endmodule

// File: rtl/ctag_way_match.sv
module ctag_way_match #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2,
  parameter int TAG_W = 22
) (
  input  logic [WAYS-1:0]  way_valid,
  input  logic [WAYS-1:0]  way_dirty,
  input  logic [TAG_W-1:0] way_tag [WAYS],
  input  logic [TAG_W-1:0] want_tag,
  output logic [WAYS-1:0]  hit_vec,
  output logic             hit_any,
  output logic [WAY_W-1:0] hit_way,
  output logic             hit_dirty
);

  function automatic logic [WAY_W-1:0] lowest_way(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (v[i]) r = WAY_W'(i);
    end
    return r;
  endfunction

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = way_valid[w] && (way_tag[w] == want_tag);
  end

  assign hit_any   = |hit_vec;
  assign hit_way   = lowest_way(hit_vec);
  assign hit_dirty = hit_any && way_dirty[hit_way];

endmodule

// File: rtl/ctag_lookup.sv
module ctag_lookup
  import ctag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 64,
  parameter int LINE_BYTES = 16,
  parameter int SHADOW_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lkp_req,
  input  logic [ADDR_W-1:0]       lkp_addr,
  input  logic                    fill_en,
  input  logic [ADDR_W-1:0]       fill_addr,
  input  logic [$clog2(WAYS)-1:0] fill_way,
  input  logic                    mark_en,
  input  logic [ADDR_W-1:0]       mark_addr,
  input  logic [$clog2(WAYS)-1:0] mark_way,
  input  logic                    drop_en,
  input  logic [ADDR_W-1:0]       drop_addr,
  input  logic [$clog2(WAYS)-1:0] drop_way,
  input  logic                    vict_req,
  input  logic [ADDR_W-1:0]       vict_addr,
  input  logic [$clog2(WAYS)-1:0] vict_way,
  output logic                    res_vld,
  output logic [WAYS-1:0]         hit_vec,
  output logic                    hit_any,
  output logic [$clog2(WAYS)-1:0] hit_way,
  output logic                    hit_dirty,
  output logic                    vict_vld,
  output logic                    vict_live,
  output logic                    vict_dirty,
  output logic [ADDR_W-$clog2(SETS)-$clog2(LINE_BYTES)-1:0] vict_tag
);

  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int IDX_W   = $clog2(SETS);
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W   = $clog2(WAYS);
  localparam int N_SPLIT = 5;
  localparam int SP_LKP  = 0;
  localparam int SP_FILL = 1;
  localparam int SP_MARK = 2;
  localparam int SP_DROP = 3;
  localparam int SP_VICT = 4;

  // Address decomposition, one splitter per address port.
  logic [ADDR_W-1:0] sp_addr [N_SPLIT];
  logic [IDX_W-1:0]  sp_idx  [N_SPLIT];
  logic [TAG_W-1:0]  sp_tag  [N_SPLIT];

  assign sp_addr[SP_LKP]  = lkp_addr;
  assign sp_addr[SP_FILL] = fill_addr;
  assign sp_addr[SP_MARK] = mark_addr;
  assign sp_addr[SP_DROP] = drop_addr;
  assign sp_addr[SP_VICT] = vict_addr;

  for (genvar p = 0; p < N_SPLIT; p++) begin : g_split
    ctag_addr_split #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
      .TAG_W(TAG_W), .SHADOW_W(SHADOW_W)
    ) u_split (
      .addr(sp_addr[p]),
      .idx (sp_idx[p]),
      .tag (sp_tag[p])
    );
  end

  logic unused_tags;
  assign unused_tags = ^{sp_tag[SP_MARK], sp_tag[SP_DROP], sp_tag[SP_VICT]};

  // Per-way storage.
  logic [WAYS-1:0]  lk_valid, lk_dirty, vk_valid, vk_dirty;
  logic [TAG_W-1:0] lk_tag [WAYS];
  logic [TAG_W-1:0] vk_tag [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    ctag_way_store #(
      .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill_we   (fill_en && (fill_way == WAY_W'(w))),
      .fill_idx  (sp_idx[SP_FILL]),
      .fill_tag  (sp_tag[SP_FILL]),
      .drop_we   (drop_en && (drop_way == WAY_W'(w))),
      .drop_idx  (sp_idx[SP_DROP]),
      .mark_we   (mark_en && (mark_way == WAY_W'(w))),
      .mark_idx  (sp_idx[SP_MARK]),
      .look_idx  (sp_idx[SP_LKP]),
      .look_valid(lk_valid[w]),
      .look_dirty(lk_dirty[w]),
      .look_tag  (lk_tag[w]),
      .vict_idx  (sp_idx[SP_VICT]),
      .vict_valid(vk_valid[w]),
      .vict_dirty(vk_dirty[w]),
      .vict_tag  (vk_tag[w])
    );
  end

  // Lookup compare (pre-update state).
  logic [WAYS-1:0]  look_hit_vec;
  logic             look_hit_any;
  logic [WAY_W-1:0] look_hit_way;
  logic             look_hit_dirty;

  ctag_way_match #(
    .WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)
  ) u_match (
    .way_valid(lk_valid),
    .way_dirty(lk_dirty),
    .way_tag  (lk_tag),
    .want_tag (sp_tag[SP_LKP]),
    .hit_vec  (look_hit_vec),
    .hit_any  (look_hit_any),
    .hit_way  (look_hit_way),
    .hit_dirty(look_hit_dirty)
  );

  // Victim selection (pre-update state).
  logic             victim_live_now;
  logic             victim_dirty_now;
  logic [TAG_W-1:0] victim_tag_now;

  assign victim_live_now  = vk_valid[vict_way];
  assign victim_dirty_now = vk_dirty[vict_way];
  assign victim_tag_now   = vk_tag[vict_way];

  // Registered results.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld    <= 1'b0;
      hit_vec    <= '0;
      hit_any    <= 1'b0;
      hit_way    <= '0;
      hit_dirty  <= 1'b0;
      vict_vld   <= 1'b0;
      vict_live  <= 1'b0;
      vict_dirty <= 1'b0;
      vict_tag   <= '0;
    end else begin
      res_vld    <= lkp_req;
      hit_vec    <= lkp_req ? look_hit_vec : '0;
      hit_any    <= lkp_req && look_hit_any;
      hit_way    <= lkp_req ? look_hit_way : '0;
      hit_dirty  <= lkp_req && look_hit_dirty;
      vict_vld   <= vict_req;
      vict_live  <= vict_req && victim_live_now;
      vict_dirty <= vict_req && victim_dirty_now;
      vict_tag   <= vict_req ? victim_tag_now : '0;
    end
  end

endmodule

// File: rtl/ctag_lookup_chk.sv
module ctag_lookup_chk #(
  parameter int WAYS     = 4,
  parameter int WAY_W    = 2,
  parameter int TAG_W    = 22,
  parameter int SHADOW_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lkp_req,
  input logic             vict_req,
  input logic             res_vld,
  input logic [WAYS-1:0]  hit_vec,
  input logic             hit_any,
  input logic [WAY_W-1:0] hit_way,
  input logic             hit_dirty,
  input logic             vict_vld,
  input logic             vict_live,
  input logic             vict_dirty,
  input logic [TAG_W-1:0] vict_tag
);

  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  AST_RES_LATENCY: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    res_vld == $past(lkp_req)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> (hit_vec == '0 && !hit_any && !hit_dirty && hit_way == '0)); // R2
  AST_HIT_WAY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> hit_vec[hit_way]); // R3
  AST_HIT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> ((hit_vec & ((WAYS'(1) << hit_way) - WAYS'(1))) == '0)); // R3
  AST_DIRTY_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit_dirty |-> hit_any); // R3
  AST_SHADOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    vict_live |-> (vict_tag[TAG_W-1 -: SHADOW_W] == '0)); // R4
  AST_DIRTY_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    vict_dirty |-> vict_live); // R7
  AST_VICT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    vict_vld == $past(vict_req)); // R10
  AST_VICT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !vict_vld |-> (!vict_live && !vict_dirty && vict_tag == '0)); // R10

endmodule

bind ctag_lookup ctag_lookup_chk #(
  .WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W), .SHADOW_W(SHADOW_W)
) u_ctag_chk (
  .clk(clk), .rst_n(rst_n), .lkp_req(lkp_req), .vict_req(vict_req),
  .res_vld(res_vld), .hit_vec(hit_vec), .hit_any(hit_any), .hit_way(hit_way),
  .hit_dirty(hit_dirty), .vict_vld(vict_vld), .vict_live(vict_live),
  .vict_dirty(vict_dirty), .vict_tag(vict_tag)
);

// File: tb/ctag_lookup_bench.sv
module ctag_lookup_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lkp_req = 0, fill_en = 0, mark_en = 0, drop_en = 0, vict_req = 0;
  logic [31:0] lkp_addr = 0, fill_addr = 0, mark_addr = 0, drop_addr = 0, vict_addr = 0;
  logic [1:0]  fill_way = 0, mark_way = 0, drop_way = 0, vict_way = 0;
  logic        res_vld, hit_any, hit_dirty, vict_vld, vict_live, vict_dirty;
  logic [3:0]  hit_vec;
  logic [1:0]  hit_way;
  logic [21:0] vict_tag;

  always #10 clk = ~clk;  // 50 MHz

  ctag_lookup u_ctag_lookup (
    .clk(clk), .rst_n(rst_n),
    .lkp_req(lkp_req), .lkp_addr(lkp_addr),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_way(fill_way),
    .mark_en(mark_en), .mark_addr(mark_addr), .mark_way(mark_way),
    .drop_en(drop_en), .drop_addr(drop_addr), .drop_way(drop_way),
    .vict_req(vict_req), .vict_addr(vict_addr), .vict_way(vict_way),
    .res_vld(res_vld), .hit_vec(hit_vec), .hit_any(hit_any), .hit_way(hit_way),
    .hit_dirty(hit_dirty), .vict_vld(vict_vld), .vict_live(vict_live),
    .vict_dirty(vict_dirty), .vict_tag(vict_tag)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Address arithmetic restated from the requirements.
  function automatic int set_of(input logic [31:0] a);
    return int'((a / 32'd16) % 32'd64);
  endfunction
  function automatic logic [21:0] tag_of(input logic [31:0] a);
    return 22'((a % 32'h2000_0000) / 32'd1024);
  endfunction

  // Reference model.
  bit          m_valid [64][4];
  bit          m_dirty [64][4];
  bit          m_known [64][4];
  logic [21:0] m_tag   [64][4];
  logic        e_res_vld, e_hit_any, e_hit_dirty, e_vict_vld, e_vict_live, e_vict_dirty;
  logic [3:0]  e_hit_vec;
  logic [1:0]  e_hit_way;
  logic [21:0] e_vict_tag;
  bit          e_vict_known;
  int          ms, mw;
  logic [21:0] mt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 64; s++) for (int w = 0; w < 4; w++) begin
        m_valid[s][w] = 0; m_dirty[s][w] = 0;
      end
      e_res_vld = 0; e_hit_vec = 0; e_hit_any = 0; e_hit_way = 0; e_hit_dirty = 0;
      e_vict_vld = 0; e_vict_live = 0; e_vict_dirty = 0; e_vict_tag = 0; e_vict_known = 1;
    end else begin
      e_res_vld = lkp_req; e_hit_vec = 0; e_hit_any = 0; e_hit_way = 0; e_hit_dirty = 0;
      if (lkp_req) begin
        ms = set_of(lkp_addr); mt = tag_of(lkp_addr);
        for (int w = 3; w >= 0; w--) begin
          if (m_valid[ms][w] && m_tag[ms][w] == mt) begin
            e_hit_vec[w] = 1; e_hit_any = 1; e_hit_way = 2'(w); e_hit_dirty = m_dirty[ms][w];
          end
        end
      end
      e_vict_vld = vict_req; e_vict_live = 0; e_vict_dirty = 0; e_vict_tag = 0; e_vict_known = 1;
      if (vict_req) begin
        ms = set_of(vict_addr); mw = int'(vict_way);
        e_vict_live = m_valid[ms][mw]; e_vict_dirty = m_dirty[ms][mw];
        e_vict_tag = m_tag[ms][mw]; e_vict_known = m_known[ms][mw];
      end
      // Apply lowest priority first so later ones override (R8).
      if (mark_en) begin
        ms = set_of(mark_addr); mw = int'(mark_way);
        if (m_valid[ms][mw]) m_dirty[ms][mw] = 1;
      end
      if (drop_en) begin
        ms = set_of(drop_addr); mw = int'(drop_way);
        m_valid[ms][mw] = 0; m_dirty[ms][mw] = 0;
      end
      if (fill_en) begin
        ms = set_of(fill_addr); mw = int'(fill_way);
        m_valid[ms][mw] = 1; m_dirty[ms][mw] = 0;
        m_tag[ms][mw] = tag_of(fill_addr); m_known[ms][mw] = 1;
      end
    end
  end

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (!done) begin
      chk(res_vld === e_res_vld, "R2", "res_vld", 32'(res_vld), 32'(e_res_vld));
      chk(hit_vec === e_hit_vec, "R2", "hit_vec", 32'(hit_vec), 32'(e_hit_vec));
      chk(hit_any === e_hit_any, "R3", "hit_any", 32'(hit_any), 32'(e_hit_any));
      chk(hit_way === e_hit_way, "R3", "hit_way", 32'(hit_way), 32'(e_hit_way));
      chk(hit_dirty === e_hit_dirty, "R3", "hit_dirty", 32'(hit_dirty), 32'(e_hit_dirty));
      chk(vict_vld === e_vict_vld, "R10", "vict_vld", 32'(vict_vld), 32'(e_vict_vld));
      chk(vict_live === e_vict_live, "R10", "vict_live", 32'(vict_live), 32'(e_vict_live));
      chk(vict_dirty === e_vict_dirty, "R10", "vict_dirty", 32'(vict_dirty), 32'(e_vict_dirty));
      if (e_vict_known)
        chk(vict_tag === e_vict_tag, "R10", "vict_tag", 32'(vict_tag), 32'(e_vict_tag));
    end
  end

  // Stimulus helpers: set inputs at a falling edge, then tick.
  task automatic idle_all();
    lkp_req = 0; fill_en = 0; mark_en = 0; drop_en = 0; vict_req = 0;
  endtask
  task automatic tick();
    @(negedge clk);
    idle_all();
  endtask
  task automatic look(input logic [31:0] a);
    lkp_req = 1; lkp_addr = a; tick();
  endtask
  task automatic vict(input logic [31:0] a, input logic [1:0] w);
    vict_req = 1; vict_addr = a; vict_way = w; tick();
  endtask
  task automatic fill(input logic [31:0] a, input logic [1:0] w);
    fill_en = 1; fill_addr = a; fill_way = w; tick();
  endtask
  task automatic mark(input logic [31:0] a, input logic [1:0] w);
    mark_en = 1; mark_addr = a; mark_way = w; tick();
  endtask
  task automatic drop(input logic [31:0] a, input logic [1:0] w);
    drop_en = 1; drop_addr = a; drop_way = w; tick();
  endtask

  function automatic logic [31:0] pick_addr();
    logic [18:0] t19;
    logic [5:0]  s6;
    int ti, si;
    ti = $urandom_range(0, 3);
    si = $urandom_range(0, 2);
    t19 = (ti == 0) ? 19'h0 : (ti == 1) ? 19'h1 : (ti == 2) ? 19'h7FFFF : 19'h2A5A5;
    s6  = (si == 0) ? 6'd0 : (si == 1) ? 6'd1 : 6'd63;
    return {3'($urandom), t19, s6, 4'($urandom)};
  endfunction

  task automatic report();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  localparam logic [31:0] A = 32'h1234_5670;
  localparam logic [31:0] B = 32'hF00A_BC80;
  localparam logic [31:0] F = 32'h0000_4010;
  localparam logic [31:0] G = 32'h0ABC_D010;
  localparam logic [31:0] C = 32'h0000_03F0;

  initial begin
    idle_all();
    repeat (3) @(negedge clk);
    chk(res_vld === 0 && vict_vld === 0 && hit_any === 0, "R11", "outputs in reset", 32'({res_vld, vict_vld, hit_any}), 0);
    rst_n = 1;
    @(negedge clk);
    look(32'h0000_1230);
    chk(hit_any === 0, "R11", "no hit after reset", 32'(hit_any), 0);
    vict(32'h0, 2'd0);
    chk(vict_live === 0 && vict_dirty === 0, "R11", "flags clear after reset", 32'({vict_live, vict_dirty}), 0);

    // R5 fill
    fill(A, 2'd2);
    look(A);
    chk(hit_any === 1 && hit_way === 2'd2, "R5", "fill then hit way", 32'({hit_any, hit_way}), 32'h6);
    chk(hit_dirty === 0, "R5", "fill leaves clean", 32'(hit_dirty), 0);

    // R1 address fields
    look(A + 32'hF);
    chk(hit_any === 1, "R1", "offset ignored", 32'(hit_any), 1);
    look(A ^ 32'h10);
    chk(hit_any === 0, "R1", "set bit differs", 32'(hit_any), 0);
    look(A ^ 32'h400);
    chk(hit_any === 0, "R1", "tag bit differs", 32'(hit_any), 0);

    // R4 shadow bits
    look(A | 32'hE000_0000);
    chk(hit_any === 1 && hit_way === 2'd2, "R4", "shadow ignored on compare", 32'({hit_any, hit_way}), 32'h6);
    fill(B, 2'd1);
    vict(B, 2'd1);
    chk(vict_tag === tag_of(B), "R4", "stored tag masked", 32'(vict_tag), 32'(tag_of(B)));
    chk(vict_tag[21:19] === 3'b000, "R4", "shadow field zero", 32'(vict_tag[21:19]), 0);

    // R6 mark
    mark(A ^ 32'hFFC0_0000, 2'd2);
    look(A);
    chk(hit_dirty === 1, "R6", "mark sets dirty", 32'(hit_dirty), 1);
    mark(A, 2'd0);
    vict(A, 2'd0);
    chk(vict_live === 0 && vict_dirty === 0, "R6", "mark on invalid ignored", 32'({vict_live, vict_dirty}), 0);

    // R3 duplicate tag in two ways
    fill(A, 2'd3);
    look(A);
    chk(hit_vec === 4'b1100 && hit_way === 2'd2, "R3", "lowest way wins", 32'({hit_vec, hit_way}), 32'h32);
    chk(hit_dirty === 1, "R3", "dirty of lowest way", 32'(hit_dirty), 1);

    // R7 invalidate
    drop(A, 2'd2);
    look(A);
    chk(hit_way === 2'd3 && hit_dirty === 0, "R7", "dropped way gone", 32'({hit_way, hit_dirty}), 32'h6);
    vict(A, 2'd2);
    chk(vict_live === 0 && vict_dirty === 0, "R7", "flags cleared", 32'({vict_live, vict_dirty}), 0);

    // R8 same-entry priority
    fill_en = 1; fill_addr = F; fill_way = 2'd0;
    drop_en = 1; drop_addr = F; drop_way = 2'd0; tick();
    vict(F, 2'd0);
    chk(vict_live === 1, "R8", "fill beats invalidate", 32'(vict_live), 1);
    mark_en = 1; mark_addr = F; mark_way = 2'd0;
    drop_en = 1; drop_addr = F; drop_way = 2'd0; tick();
    vict(F, 2'd0);
    chk(vict_live === 0 && vict_dirty === 0, "R8", "invalidate beats mark", 32'({vict_live, vict_dirty}), 0);
    fill_en = 1; fill_addr = F; fill_way = 2'd0;
    drop_en = 1; drop_addr = A; drop_way = 2'd3; tick();
    look(F);
    chk(hit_any === 1 && hit_way === 2'd0, "R8", "parallel fill applied", 32'({hit_any, hit_way}), 32'h4);
    look(A);
    chk(hit_any === 0, "R8", "parallel invalidate applied", 32'(hit_any), 0);

    // R9 read before write
    fill(A, 2'd1);
    lkp_req = 1; lkp_addr = A; drop_en = 1; drop_addr = A; drop_way = 2'd1; tick();
    chk(hit_any === 1, "R9", "lookup sees old state", 32'(hit_any), 1);
    look(A);
    chk(hit_any === 0, "R9", "update visible next", 32'(hit_any), 0);
    vict_req = 1; vict_addr = F; vict_way = 2'd0;
    fill_en = 1; fill_addr = G; fill_way = 2'd0; tick();
    chk(vict_tag === tag_of(F), "R9", "victim sees old tag", 32'(vict_tag), 32'(tag_of(F)));
    vict(F, 2'd0);
    chk(vict_tag === tag_of(G), "R9", "new tag after fill", 32'(vict_tag), 32'(tag_of(G)));

    // R10 victim of a written line
    mark(G, 2'd0);
    vict(G, 2'd0);
    chk(vict_live === 1 && vict_dirty === 1, "R10", "dirty victim", 32'({vict_live, vict_dirty}), 32'h3);

    // R11 reset keeps tags
    fill(C, 2'd1);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    vict(C, 2'd1);
    chk(vict_live === 0 && vict_tag === tag_of(C), "R11", "tag survives reset", 32'({vict_live, vict_tag}), 32'(tag_of(C)));
    look(G);
    chk(hit_any === 0, "R11", "no hit after reset", 32'(hit_any), 0);

    // Random traffic compared every cycle against the model.
    for (int i = 0; i < 4000; i++) begin
      lkp_req   = 1'($urandom);  lkp_addr  = pick_addr();
      fill_en   = ($urandom_range(0, 3) == 0); fill_addr = pick_addr(); fill_way = 2'($urandom);
      mark_en   = ($urandom_range(0, 2) == 0); mark_addr = pick_addr(); mark_way = 2'($urandom);
      drop_en   = ($urandom_range(0, 4) == 0); drop_addr = pick_addr(); drop_way = 2'($urandom);
      vict_req  = 1'($urandom);  vict_addr = pick_addr(); vict_way = 2'($urandom);
      @(negedge clk);
    end
    idle_all();
    repeat (2) @(negedge clk);
    report();
  end

endmodule